// File: doc/BRIEF.md
# Receiver Error Filter with Sample Hold Control

This block sits behind the frame decoder of a digital audio receiver. Seven single-cycle error flags arrive from the decoder. Each flag passes through its own enable bit. An enabled error is latched into a readable error register, drives an error pin and raises a one-cycle interrupt request. If the error can damage audio data, it also decides what the output stage does with the current sample.

Software writes the enable mask and the hold mode through a small write port. Reading the error register is signalled by a strobe, and that strobe empties the register. The audio path pulses a strobe once per sample. On that strobe the block reports whether to pass, repeat or zero the sample. The two checksum errors that cover channel metadata are reported like any other error, but they never touch the audio.

Top module: `rx_err_filter`

## Requirements
- R1: Input bit k of `err_raw_i` maps to bit k of `err_reg_o`, with this assignment: 6 = Q-subcode checksum, 5 = channel-status checksum, 4 = PLL unlock, 3 = validity, 2 = confidence, 1 = biphase coding, 0 = parity. Bit 7 of `err_reg_o` always reads 0.
- R2: After reset the enable mask is 0, so every error is suppressed. The hold mode is 00. A write with `cfg_we_i`=1 and `cfg_sel_i`=0 loads the mask from `cfg_wdata_i[6:0]`. A write with `cfg_sel_i`=1 loads the hold mode from `cfg_wdata_i[1:0]`. Either value takes effect in the cycle after the write.
- R3: An error whose mask bit is 0 sets no register bit, does not drive the pin, raises no interrupt and does not change the sample action.
- R4: Register bits are sticky. An enabled error shows in `err_reg_o` after the next clock edge. A cycle with `rd_clr_i`=1 clears the register at that edge. An enabled error in the same cycle as the clear stays set.
- R5: `err_pin_o` is high exactly when some bit of `err_reg_o` is set and its mask bit is currently 1.
- R6: `err_irq_o` is high for one cycle, after the edge that ends a cycle in which any enabled error was present on the input.
- R7: Bits 6 and 5 never change the sample action, even when they are enabled.
- R8: `smp_act_o` resets to pass (00). It changes only at the edge that ends a cycle with `smp_stb_i`=1. It then shows the action for any enabled audio-affecting error seen from the cycle after the previous strobe up to and including the strobe cycle, or pass if there was none.
- R9: Action codes are 00 = pass, 01 = repeat the last good sample, 10 = output zero. Hold mode 00 selects repeat, 01 selects zero, and 10 and 11 select pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| err_raw_i | input | 7 | Error pulses from the decoder |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Write target: 0 = mask, 1 = hold mode |
| cfg_wdata_i | input | 7 | Configuration write data |
| rd_clr_i | input | 1 | Error register read strobe, clears the register |
| smp_stb_i | input | 1 | One pulse per audio sample |
| err_reg_o | output | 8 | Error register contents |
| err_pin_o | output | 1 | Error pin |
| err_irq_o | output | 1 | Error interrupt request pulse |
| smp_act_o | output | 2 | Action for the current sample |

## Verification
Two pairs of events can land on the same edge. The first pair is an enabled error and the register read strobe. The second is an enabled error and the sample strobe. A directed case raises parity together with `rd_clr_i` and expects the bit to survive. Another directed case raises an error on the strobe cycle itself and expects it to count toward that sample. Random stimulus keeps both collisions frequent, and a reference model that applies "error wins over clear" and "strobe-cycle errors count" judges every cycle.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int ERR_W = 7;
  localparam int REG_W = 8;
  localparam int QSUB_POS = 6;
  localparam int CSTAT_POS = 5;

  typedef enum logic [1:0] {
    HOLD_REPEAT = 2'b00,
    HOLD_ZERO   = 2'b01,
    HOLD_PASS   = 2'b10,
    HOLD_PASS_B = 2'b11
  } hold_mode_e;

  typedef enum logic [1:0] {
    ACT_PASS   = 2'b00,
    ACT_REPEAT = 2'b01,
    ACT_ZERO   = 2'b10
  } smp_act_e;

  function automatic smp_act_e mode_to_act(hold_mode_e m);
    case (m)
      HOLD_REPEAT: return ACT_REPEAT;
      HOLD_ZERO:   return ACT_ZERO;
      default:     return ACT_PASS;
    endcase
  endfunction
endpackage

// File: rtl/rxerr_rst_sync.sv
module rxerr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rxerr_cfg.sv
module rxerr_cfg
  import rxerr_pkg::*;
#(
  parameter int W = ERR_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask,
  output hold_mode_e mode
);
  logic [W-1:0] mask_q, mask_d;
  hold_mode_e   mode_q, mode_d;
  logic         mask_en, mode_en;

  always_comb begin
    mask_en = we && !sel;
    mode_en = we && sel;
    mask_d  = wdata;
    mode_d  = hold_mode_e'(wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= HOLD_REPEAT;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mask = mask_q;
  assign mode = mode_q;

  // R2: a mask write lands on the next edge
  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we && !sel) |-> mask == $past(wdata));
  // R2: the mask does not move without a write
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we && !sel) |-> $stable(mask));
endmodule

// File: rtl/rxerr_sticky.sv
module rxerr_sticky #(
  parameter int W = rxerr_pkg::ERR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] mask,
  input  logic         rd_clr,
  output logic [W-1:0] err_q,
  output logic         pin,
  output logic         irq
);
  logic [W-1:0] hit;
  logic [W-1:0] err_d;
  logic         irq_d, irq_q;

  assign hit = raw & mask;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb err_d[i] = (rd_clr ? 1'b0 : err_q[i]) | hit[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q[i] <= 1'b0;
      else        err_q[i] <= err_d[i];
    end
  end

  always_comb irq_d = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign pin = |(err_q & mask);
  assign irq = irq_q;

  // R3: a bit may only become set by an enabled error on the input
  p_set_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_q & ~$past(err_q)) & ~$past(raw & mask)) == '0);
  // R4: without a read, set bits stay set
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_clr) |-> ((err_q & $past(err_q)) == $past(err_q)));
  // R4: a read with no new error empties the register
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_clr) && ($past(raw & mask) == '0)) |-> err_q == '0);
  // R6: the interrupt pulse follows an enabled error
  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(raw & mask) != '0));
endmodule

// File: rtl/rxerr_hold.sv
module rxerr_hold
  import rxerr_pkg::*;
#(
  parameter int W = ERR_W,
  parameter int CRC_A = QSUB_POS,
  parameter int CRC_B = CSTAT_POS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] mask,
  input  hold_mode_e mode,
  input  logic       stb,
  output smp_act_e   act
);
  logic [W-1:0] aud_sel;
  logic         new_hit, any_hit;
  logic         acc_q, acc_d;
  smp_act_e     act_q, act_d;

  for (genvar i = 0; i < W; i++) begin : g_sel
    assign aud_sel[i] = (i != CRC_A) && (i != CRC_B);
  end

  always_comb begin
    new_hit = |(raw & mask & aud_sel);
    any_hit = acc_q | new_hit;
    acc_d   = stb ? 1'b0 : any_hit;
    act_d   = any_hit ? mode_to_act(mode) : ACT_PASS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 1'b0;
    else        acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   act_q <= ACT_PASS;
    else if (stb) act_q <= act_d;
  end

  assign act = act_q;

  // R8: the action moves only on a sample strobe
  p_act_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb) |-> $stable(act));
  // R7: a strobe with only checksum errors pending yields pass
  p_crc_only_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !acc_q && ((raw & aud_sel) == '0)) |=> act == ACT_PASS);
endmodule

// File: rtl/rx_err_filter.sv
module rx_err_filter
  import rxerr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] err_raw_i,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [ERR_W-1:0] cfg_wdata_i,
  input  logic             rd_clr_i,
  input  logic             smp_stb_i,
  output logic [REG_W-1:0] err_reg_o,
  output logic             err_pin_o,
  output logic             err_irq_o,
  output logic [1:0]       smp_act_o
);
  localparam int PAD_W = REG_W - ERR_W;

  logic             rst_ni;
  logic [ERR_W-1:0] mask;
  hold_mode_e       mode;
  logic [ERR_W-1:0] err_q;
  smp_act_e         act;

  rxerr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni)
  );

  rxerr_cfg #(.W(ERR_W)) u_cfg (
    .clk(clk), .rst_n(rst_ni), .we(cfg_we_i), .sel(cfg_sel_i),
    .wdata(cfg_wdata_i), .mask(mask), .mode(mode)
  );

  rxerr_sticky #(.W(ERR_W)) u_sticky (
    .clk(clk), .rst_n(rst_ni), .raw(err_raw_i), .mask(mask),
    .rd_clr(rd_clr_i), .err_q(err_q), .pin(err_pin_o), .irq(err_irq_o)
  );

  rxerr_hold #(.W(ERR_W), .CRC_A(QSUB_POS), .CRC_B(CSTAT_POS)) u_hold (
    .clk(clk), .rst_n(rst_ni), .raw(err_raw_i), .mask(mask),
    .mode(mode), .stb(smp_stb_i), .act(act)
  );

  assign err_reg_o = {{PAD_W{1'b0}}, err_q};
  assign smp_act_o = act;

  // R5: the pin never rises while the register is empty
  p_pin_needs_bit_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    err_pin_o |-> (err_reg_o != '0));
  // R1: the unused top bit stays clear
  p_top_bit_clear_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    err_reg_o[REG_W-1] == 1'b0);
endmodule

// File: tb/tb_rx_err_filter.sv
module tb_rx_err_filter;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N_RAND = 4000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] err_raw_i = '0;
  logic       cfg_we_i = 1'b0;
  logic       cfg_sel_i = 1'b0;
  logic [6:0] cfg_wdata_i = '0;
  logic       rd_clr_i = 1'b0;
  logic       smp_stb_i = 1'b0;
  logic [7:0] err_reg_o;
  logic       err_pin_o, err_irq_o;
  logic [1:0] smp_act_o;

  int n_run = 0, n_fail = 0, cycles = 0;
  logic       done = 1'b0;

  logic [6:0] m_mask = '0, m_err = '0;
  logic [1:0] m_mode = '0, m_act = '0;
  logic       m_irq = 1'b0, m_acc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_err_filter dut (.*);

  function automatic logic [1:0] act_of(logic [1:0] mode);
    case (mode)
      2'b00:   return 2'b01;
      2'b01:   return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(logic [6:0] raw, logic we, logic sel, logic [6:0] wd,
                     logic rd, logic stb);
    logic [6:0] hit;
    logic       any;
    @(negedge clk);
    err_raw_i = raw; cfg_we_i = we; cfg_sel_i = sel; cfg_wdata_i = wd;
    rd_clr_i = rd; smp_stb_i = stb;
    @(posedge clk);
    hit   = raw & m_mask;
    m_err = (rd ? 7'd0 : m_err) | hit;
    m_irq = |hit;
    any   = m_acc | (|(hit & 7'h1F));
    if (stb) begin
      m_act = any ? act_of(m_mode) : 2'b00;
      m_acc = 1'b0;
    end else m_acc = any;
    if (we && !sel) m_mask = wd;
    if (we && sel)  m_mode = wd[1:0];
    #1;
    chk("R4 reg", err_reg_o, {1'b0, m_err});
    chk("R5 pin", {7'd0, err_pin_o}, {7'd0, |(m_err & m_mask)});
    chk("R6 irq", {7'd0, err_irq_o}, {7'd0, m_irq});
    chk("R8 act", {6'd0, smp_act_o}, {6'd0, m_act});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R2 reset reg", err_reg_o, 8'h00);
    chk("R8 reset act", {6'd0, smp_act_o}, 8'h00);

    // R2/R3: all errors suppressed by the reset mask
    cyc(7'h7F, 0, 0, 0, 0, 1);
    chk("R3 masked reg", err_reg_o, 8'h00);
    chk("R3 masked act", {6'd0, smp_act_o}, 8'h00);
    chk("R3 masked irq", {7'd0, err_irq_o}, 8'h00);

    // R2: enable everything
    cyc(0, 1, 0, 7'h7F, 0, 0);
    // R1: each position lands on its own bit
    for (int k = 0; k < 7; k++) begin
      cyc(7'(1 << k), 0, 0, 0, 0, 0);
      chk("R1 position", err_reg_o, 8'(1 << k));
      cyc(0, 0, 0, 0, 1, 0);
    end
    // R4: error in the read cycle survives
    cyc(7'h01, 0, 0, 0, 0, 0);
    cyc(7'h01, 0, 0, 0, 1, 0);
    chk("R4 error wins over clear", err_reg_o, 8'h01);
    // R5: pin follows the current mask
    cyc(0, 1, 0, 7'h7E, 0, 0);
    chk("R5 pin drops with mask", {7'd0, err_pin_o}, 8'h00);
    cyc(0, 1, 0, 7'h7F, 1, 1);
    // R7: checksum errors alone leave pass
    cyc(7'h60, 0, 0, 0, 0, 1);
    chk("R7 crc only act", {6'd0, smp_act_o}, 8'h00);
    chk("R7 crc reported", err_reg_o, 8'h60);
    // R9: each hold mode, error raised on the strobe cycle
    for (int m = 0; m < 4; m++) begin
      cyc(0, 1, 1, 7'(m), 1, 1);
      cyc(7'h04, 0, 0, 0, 0, 1);
      chk("R9 mode action", {6'd0, smp_act_o}, {6'd0, act_of(2'(m))});
    end

    for (int i = 0; i < N_RAND; i++) begin
      logic [6:0] r;
      r = 7'($urandom & $urandom & $urandom);
      cyc(r, ($urandom % 16) == 0, $urandom % 2, 7'($urandom),
          ($urandom % 8) == 0, ($urandom % 6) == 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule